// File: doc/BRIEF.md
# Sequential Multiplier/Divider Peripheral

This block is an arithmetic peripheral on a byte-wide register port. Software writes operand A (a double-width register) and operand B (a single-width register). It then writes the control register to choose multiplication or division and to set the go bit. The unit then steps through the operation at one bit per clock.

A multiply forms the double-width product of the low half of A and B, and leaves it in A. A divide takes all of A as the dividend and B as the divisor. It leaves the quotient in A and the remainder in a separate read-only remainder register. When the last step lands, the go bit drops by itself and a sticky completion flag is raised. The flag drives the interrupt request output until software writes 1 to it.

Software may cancel a running operation by writing 0 to the go bit. If that write falls on the final step, the operation completes normally. Every register byte can be written whole, or one bit at a time through a separate bit-write strobe.

Top module: `mdu_seq`

## Requirements
- R1: After reset every register byte (addresses 0 to 9) reads 00h and `irq` is 0.
- R2: In the control register (address 8), bit 0 is the mode (1 = multiply, 0 = divide) and is readable and writable. Bits 6 to 1 ignore writes and read as 0.
- R3: Writing control bit 7 = 1 while idle starts an operation. Bit 7 then reads 1 for exactly OPW clock edges for a multiply, or 2*OPW edges for a divide, and reads 0 from the edge that completes it.
- R4: A multiply leaves {A_low * B} (full 2*OPW bits) in A, whatever the upper half of A held. The remainder register is unchanged.
- R5: A divide with B nonzero leaves A / B in A and A mod B in the remainder register (bytes 6 and 7, little-endian).
- R6: A divide by B = 0 completes normally. A reads all ones and the remainder equals the low OPW bits of the dividend.
- R7: Completion sets the sticky flag (status address 9, bit 0), which drives `irq`. Writing 1 to that bit clears it and writing 0 leaves it. A clear that lands on the completing edge loses to the set.
- R8: Writing control bit 7 = 0 while busy, before the final step, stops the operation at once. Bit 7 reads 0 and the flag stays clear.
- R9: If the write of bit 7 = 0 lands on the final step's edge, the result is valid and the flag is set.
- R10: While busy, writes to the A and B operand bytes are dropped, and writing bit 7 = 1 again neither restarts nor lengthens the operation.
- R11: A bit write (`bit_en`) changes only bit `bit_sel` of the addressed byte and leaves its other bits. A bit write to a status bit other than bit 0 leaves the flag.
- R12: After an abort, reloading A and B and setting bit 7 again runs a full, correct operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Register byte address for reads and writes |
| wr_en | input | 1 | Whole-byte write strobe |
| wr_data | input | 8 | Byte write data |
| bit_en | input | 1 | Single-bit write strobe (ignored when wr_en is high) |
| bit_sel | input | 3 | Bit position for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| rd_data | output | 8 | Combinational read data of the addressed byte |
| irq | output | 1 | Completion interrupt request (sticky flag) |

## Verification
The bench builds the block with its defaults, OPW = 16 and AW = 4, which gives a 16-edge multiply and a 32-edge divide. Those are short enough to place single writes on the exact final-step edge, so the abort-versus-completion and clear-versus-set collisions can be hit directly. Vectors cover products that fill all 32 bits, a multiplicand with a dirty upper half, and quotients of all ones. They also cover a zero quotient with a maximal divisor and a zero divisor.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
   localparam int unsigned CTL_GO    = 7;
   localparam int unsigned CTL_MODE  = 0;
   localparam int unsigned STAT_DONE = 0;

   typedef enum logic {
      MODE_DIV = 1'b0,
      MODE_MUL = 1'b1
   } mode_e;
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
   import mdu_pkg::*;
#(
   parameter int OPW = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_we,
   input  logic [7:0] ctl_wdata,
   input  logic       stat_clr,
   output logic       busy,
   output mode_e      mode,
   output logic       last,
   output logic       start_mul,
   output logic       start_div,
   output logic       flag,
   output logic [7:0] ctl_rd
);
   localparam int STEPS_MUL = OPW;
   localparam int STEPS_DIV = 2 * OPW;
   localparam int CW        = $clog2(STEPS_DIV);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;
   logic          start;
   logic          abort;

   assign lim       = (mode == MODE_MUL) ? CW'(STEPS_MUL - 1) : CW'(STEPS_DIV - 1);
   assign last      = busy && (cnt == lim);
   assign start     = !busy && ctl_we && ctl_wdata[CTL_GO];
   assign abort     = busy && ctl_we && !ctl_wdata[CTL_GO];
   assign start_mul = start && ctl_wdata[CTL_MODE];
   assign start_div = start && !ctl_wdata[CTL_MODE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         mode <= MODE_DIV;
         flag <= 1'b0;
      end else begin
         if (ctl_we)
            mode <= mode_e'(ctl_wdata[CTL_MODE]);
         if (last)
            busy <= 1'b0;
         else if (abort)
            busy <= 1'b0;
         else if (start)
            busy <= 1'b1;
         if (start)
            cnt <= '0;
         else if (busy)
            cnt <= cnt + 1'b1;
         if (last)
            flag <= 1'b1;
         else if (stat_clr)
            flag <= 1'b0;
      end
   end

   always_comb begin
      ctl_rd           = '0;
      ctl_rd[CTL_GO]   = busy;
      ctl_rd[CTL_MODE] = mode;
   end

   p_start_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ctl_we && ctl_wdata[CTL_GO]) |=> (busy && cnt == '0));
   p_done_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (flag && !busy));
   p_flag_sticky_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !stat_clr) |=> flag);
   p_abort_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last && ctl_we && !ctl_wdata[CTL_GO]) |=> (!busy && $stable(flag)));
endmodule

// File: rtl/mdu_mul_step.sv
module mdu_mul_step #(
   parameter int W = 16
) (
   input  logic [2*W-1:0] a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] a_nx
);
   logic [W:0] sum;

   always_comb begin
      sum  = {1'b0, a[2*W-1:W]} + (a[0] ? {1'b0, b} : '0);
      a_nx = {sum, a[W-1:1]};
   end
endmodule

// File: rtl/mdu_div_step.sv
module mdu_div_step #(
   parameter int W = 16
) (
   input  logic [2*W-1:0] a,
   input  logic [W-1:0]   b,
   input  logic [W-1:0]   r,
   output logic [2*W-1:0] a_nx,
   output logic [W-1:0]   r_nx
);
   logic [W:0] trial;
   logic [W:0] diff;
   logic       fits;

   always_comb begin
      trial = {r, a[2*W-1]};
      fits  = (trial >= {1'b0, b});
      diff  = trial - {1'b0, b};
      r_nx  = fits ? diff[W-1:0] : trial[W-1:0];
      a_nx  = {a[2*W-2:0], fits};
   end
endmodule

// File: rtl/mdu_seq.sv
module mdu_seq
   import mdu_pkg::*;
#(
   parameter int OPW = 16,
   parameter int AW  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          wr_en,
   input  logic [7:0]    wr_data,
   input  logic          bit_en,
   input  logic [2:0]    bit_sel,
   input  logic          bit_val,
   output logic [7:0]    rd_data,
   output logic          irq
);
   localparam int AWID     = 2 * OPW;
   localparam int NA       = AWID / 8;
   localparam int NB       = OPW / 8;
   localparam int ADR_B    = NA;
   localparam int ADR_R    = NA + NB;
   localparam int ADR_CTL  = NA + 2 * NB;
   localparam int ADR_STAT = ADR_CTL + 1;

   if (OPW < 8 || (OPW % 8) != 0) begin : g_bad_width
      $error("mdu_seq: OPW must be a positive multiple of 8");
   end
   if (ADR_STAT >= (1 << AW)) begin : g_bad_addr
      $error("mdu_seq: AW too narrow for the register map");
   end

   logic [AWID-1:0] a_q;
   logic [OPW-1:0]  b_q;
   logic [OPW-1:0]  r_q;
   logic [7:0]      ctl_rd;
   logic [7:0]      stat_rd;
   logic [7:0]      wbyte;
   logic [7:0]      bitmod;
   logic            we;
   logic            busy, last, start_mul, start_div, flag;
   mode_e           mode;
   logic            ctl_we, stat_clr;
   logic [NA-1:0]   a_we;
   logic [NB-1:0]   b_we;
   logic [AWID-1:0] mul_a_nx, div_a_nx, dp_a_nx;
   logic [OPW-1:0]  div_r_nx, dp_r_nx;

   // read mux
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NA; i++)
         if (addr == AW'(i)) rd_data = a_q[8*i +: 8];
      for (int i = 0; i < NB; i++) begin
         if (addr == AW'(ADR_B + i)) rd_data = b_q[8*i +: 8];
         if (addr == AW'(ADR_R + i)) rd_data = r_q[8*i +: 8];
      end
      if (addr == AW'(ADR_CTL))  rd_data = ctl_rd;
      if (addr == AW'(ADR_STAT)) rd_data = stat_rd;
   end

   // single-bit writes are read-modify-write of the addressed byte
   always_comb begin
      bitmod          = rd_data;
      bitmod[bit_sel] = bit_val;
      wbyte           = wr_en ? wr_data : bitmod;
   end
   assign we = wr_en || bit_en;

   genvar gi;
   for (gi = 0; gi < NA; gi++) begin : g_a_lane
      assign a_we[gi] = we && !busy && (addr == AW'(gi));
   end
   for (gi = 0; gi < NB; gi++) begin : g_b_lane
      assign b_we[gi] = we && !busy && (addr == AW'(ADR_B + gi));
   end

   assign ctl_we   = we && (addr == AW'(ADR_CTL));
   assign stat_clr = (addr == AW'(ADR_STAT)) &&
                     (wr_en ? wr_data[STAT_DONE]
                            : (bit_en && bit_sel == 3'(STAT_DONE) && bit_val));

   always_comb begin
      stat_rd            = '0;
      stat_rd[STAT_DONE] = flag;
   end
   assign irq = flag;

   mdu_ctrl #(.OPW(OPW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we),
      .ctl_wdata (wbyte),
      .stat_clr  (stat_clr),
      .busy      (busy),
      .mode      (mode),
      .last      (last),
      .start_mul (start_mul),
      .start_div (start_div),
      .flag      (flag),
      .ctl_rd    (ctl_rd)
   );

   mdu_mul_step #(.W(OPW)) u_mul (
      .a    (a_q),
      .b    (b_q),
      .a_nx (mul_a_nx)
   );

   mdu_div_step #(.W(OPW)) u_div (
      .a    (a_q),
      .b    (b_q),
      .r    (r_q),
      .a_nx (div_a_nx),
      .r_nx (div_r_nx)
   );

   assign dp_a_nx = (mode == MODE_MUL) ? mul_a_nx : div_a_nx;
   assign dp_r_nx = (mode == MODE_MUL) ? r_q : div_r_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         r_q <= '0;
      end else if (busy) begin
         a_q <= dp_a_nx;
         r_q <= dp_r_nx;
      end else begin
         if (start_mul)
            a_q[AWID-1:OPW] <= '0;
         if (start_div)
            r_q <= '0;
         for (int i = 0; i < NA; i++)
            if (a_we[i]) a_q[8*i +: 8] <= wbyte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         b_q <= '0;
      else
         for (int i = 0; i < NB; i++)
            if (b_we[i]) b_q[8*i +: 8] <= wbyte;
   end

   p_b_frozen_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(b_q));
   p_mul_keeps_rem_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mode == MODE_MUL) |=> $stable(r_q));
   p_idle_a_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !we) |=> $stable(a_q));
endmodule

// File: tb/tb_mdu_seq.sv
`timescale 1ns/1ps
module tb_mdu_seq;
   localparam int OPW = 16;
   localparam int AW  = 4;
   localparam logic [3:0] A_CTL  = 4'd8;
   localparam logic [3:0] A_STAT = 4'd9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       bit_en = 1'b0;
   logic [2:0] bit_sel = '0;
   logic       bit_val = 1'b0;
   logic [7:0] rd_data;
   logic       irq;

   int tests = 0;
   int fails = 0;
   logic [15:0] exp_r = '0;

   always #5 clk = ~clk;

   mdu_seq #(.OPW(OPW), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .bit_en(bit_en), .bit_sel(bit_sel), .bit_val(bit_val),
      .rd_data(rd_data), .irq(irq)
   );

   // {mul, a, b}
   localparam logic [48:0] VEC [8] = '{
      {1'b1, 32'h0000_1234, 16'h5678},
      {1'b0, 32'h1234_5678, 16'h1234},
      {1'b1, 32'h0000_FFFF, 16'hFFFF},
      {1'b0, 32'hFFFF_FFFF, 16'h0001},
      {1'b1, 32'hDEAD_0003, 16'h0005},
      {1'b0, 32'h0000_0064, 16'h0007},
      {1'b1, 32'h0000_0000, 16'hBEEF},
      {1'b0, 32'h0000_0005, 16'hFFFF}
   };

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bwr(input logic [3:0] a, input logic [2:0] s, input logic v);
      addr = a; bit_sel = s; bit_val = v; bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
   endtask

   task automatic rd8(input logic [3:0] a, output logic [7:0] v);
      addr = a;
      #0.5;
      v = rd_data;
   endtask

   task automatic rd_a(output logic [31:0] v);
      logic [7:0] t;
      for (int i = 0; i < 4; i++) begin
         rd8(4'(i), t);
         v[8*i +: 8] = t;
      end
   endtask

   task automatic rd_r(output logic [15:0] v);
      logic [7:0] t;
      rd8(4'd6, t); v[7:0]  = t;
      rd8(4'd7, t); v[15:8] = t;
   endtask

   task automatic load(input logic [31:0] a, input logic [15:0] b);
      for (int i = 0; i < 4; i++) wr(4'(i), a[8*i +: 8]);
      wr(4'd4, b[7:0]);
      wr(4'd5, b[15:8]);
   endtask

   task automatic go(input logic mul);
      wr(A_CTL, {1'b1, 6'b0, mul});
   endtask

   // n = edges remaining until completion
   task automatic wait_done(input int n, input logic mul);
      logic [7:0] v;
      repeat (n - 1) @(negedge clk);
      rd8(A_CTL, v);
      check("R3", "busy before last edge", 32'(v), {24'b0, 1'b1, 6'b0, mul});
      @(negedge clk);
      rd8(A_CTL, v);
      check("R3", "idle after last edge", 32'(v), {24'b0, 1'b0, 6'b0, mul});
   endtask

   task automatic expect_result(input string tag, input logic mul,
                                input logic [31:0] a, input logic [15:0] b);
      logic [31:0] ea, ga;
      logic [15:0] gr;
      if (mul) begin
         ea = 32'(a[15:0]) * 32'(b);
      end else if (b == 16'h0) begin
         ea = 32'hFFFF_FFFF;
         exp_r = a[15:0];
      end else begin
         ea = a / 32'(b);
         exp_r = 16'(a % 32'(b));
      end
      rd_a(ga);
      rd_r(gr);
      check(tag, "A result", ga, ea);
      check(tag, "remainder", 32'(gr), 32'(exp_r));
   endtask

   task automatic clear_flag();
      wr(A_STAT, 8'h01);
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [7:0]  v;
      logic [31:0] ga;
      logic        m;
      logic [31:0] va;
      logic [15:0] vb;

      // R1: reset values
      #3;
      for (int i = 0; i < 10; i++) begin
         rd8(4'(i), v);
         check("R1", "reset byte", 32'(v), 32'h0);
      end
      check("R1", "reset irq", 32'(irq), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reserved bits
      wr(A_CTL, 8'h7E);
      rd8(A_CTL, v);
      check("R2", "reserved ignored", 32'(v), 32'h00);
      @(negedge clk);
      wr(A_CTL, 8'h7F);
      rd8(A_CTL, v);
      check("R2", "mode bit kept", 32'(v), 32'h01);
      @(negedge clk);

      // R4/R5 vector walk
      for (int k = 0; k < 8; k++) begin
         m  = VEC[k][48];
         va = VEC[k][47:16];
         vb = VEC[k][15:0];
         load(va, vb);
         go(m);
         wait_done(m ? OPW : 2 * OPW, m);
         expect_result(m ? "R4" : "R5", m, va, vb);
         check("R7", "irq after done", 32'(irq), 32'h1);
         @(negedge clk);
         clear_flag();
      end

      // R7: clear behaviour
      load(32'h0000_0009, 16'h0003);
      go(1'b0);
      wait_done(2 * OPW, 1'b0);
      expect_result("R5", 1'b0, 32'h9, 16'h3);
      @(negedge clk);
      wr(A_STAT, 8'h00);
      check("R7", "write 0 keeps flag", 32'(irq), 32'h1);
      bwr(A_STAT, 3'd3, 1'b1);
      check("R11", "other status bit keeps flag", 32'(irq), 32'h1);
      clear_flag();
      check("R7", "write 1 clears", 32'(irq), 32'h0);

      // R7: set wins over same-edge clear
      load(32'h0000_0002, 16'h0003);
      go(1'b1);
      repeat (OPW - 1) @(negedge clk);
      wr(A_STAT, 8'h01);
      check("R7", "set beats clear", 32'(irq), 32'h1);
      clear_flag();

      // R6: divide by zero
      load(32'h89AB_CDEF, 16'h0000);
      go(1'b0);
      wait_done(2 * OPW, 1'b0);
      expect_result("R6", 1'b0, 32'h89AB_CDEF, 16'h0000);
      @(negedge clk);
      clear_flag();

      // R8: abort mid-run
      load(32'h1234_5678, 16'h0011);
      go(1'b0);
      repeat (4) @(negedge clk);
      wr(A_CTL, 8'h00);
      rd8(A_CTL, v);
      check("R8", "abort stops busy", 32'(v), 32'h00);
      repeat (40) @(negedge clk);
      check("R8", "no irq after abort", 32'(irq), 32'h0);

      // R12: rerun after abort
      load(32'h1234_5678, 16'h0011);
      go(1'b0);
      wait_done(2 * OPW, 1'b0);
      expect_result("R12", 1'b0, 32'h1234_5678, 16'h0011);
      @(negedge clk);
      clear_flag();

      // R9: abort lands on final edge
      load(32'h0000_ABCD, 16'h0102);
      go(1'b1);
      repeat (OPW - 1) @(negedge clk);
      wr(A_CTL, 8'h01);
      check("R9", "irq on collided abort", 32'(irq), 32'h1);
      expect_result("R9", 1'b1, 32'h0000_ABCD, 16'h0102);
      @(negedge clk);
      clear_flag();

      // R10: writes while busy
      load(32'h0000_0003, 16'h0007);
      go(1'b1);
      wr(4'd0, 8'hFF);
      wr(4'd4, 8'hFF);
      wr(A_CTL, 8'h81);
      wait_done(OPW - 3, 1'b1);
      rd_a(ga);
      check("R10", "busy writes dropped", ga, 32'd21);
      rd8(4'd4, v);
      check("R10", "B unchanged", 32'(v), 32'h07);
      @(negedge clk);
      clear_flag();

      // R11: bit writes for mode and go
      load(32'h0000_0100, 16'h0021);
      wr(A_CTL, 8'h00);
      bwr(A_CTL, 3'd0, 1'b1);
      rd8(A_CTL, v);
      check("R11", "bit write mode", 32'(v), 32'h01);
      bwr(A_CTL, 3'd7, 1'b1);
      wait_done(OPW, 1'b1);
      expect_result("R11", 1'b1, 32'h0000_0100, 16'h0021);
      @(negedge clk);
      bwr(A_STAT, 3'd0, 1'b1);
      check("R11", "bit write clears flag", 32'(irq), 32'h0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule